// File: doc/BRIEF.md
# Pipeline Exception Commit Unit

This unit gives a classic five-stage in-order pipeline precise exceptions. Each instruction carries its program counter and a small vector of fault flags as it moves from decode through execute into the memory stage. Faults are recorded when they are found but cause no action. Four sources exist: a fetch address fault, an illegal opcode found in decode, an arithmetic overflow found in execute, and a data address fault found in memory. Only the memory stage, which is the commit point, acts on these flags.

At commit the unit picks one cause. An external interrupt beats every synchronous fault. Among the faults, the one found in the earliest stage wins. When an exception is taken, the unit kills the fetch, decode, execute and writeback work in flight and records the cause code and the faulting PC. In the next cycle it steers fetch to a fixed handler address. An instruction that commits with no exception passes into writeback.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset, cause_o is 0, epc_o is 0, redirect_o is 0 and wb_valid_o is 0.
- R2: take_o is asserted only while a valid instruction is at the memory stage and has a fault flag or meets an asserted irq_i. A fault seen in decode or execute raises nothing until that instruction reaches the memory stage.
- R3: Without an interrupt, cause_o takes the code of the earliest-stage fault of the committing instruction. The codes are 1 for a fetch fault, 2 for an illegal opcode, 3 for an overflow and 4 for a data address fault, so fetch beats illegal, illegal beats overflow and overflow beats data address.
- R4: When irq_i is high while a valid instruction is at commit, that instruction is taken with cause code 0, whatever flags it carries.
- R5: An interrupt is ignored in any cycle with no valid instruction at the memory stage. take_o stays low and cause_o and epc_o keep their values.
- R6: In the cycle after a take, cause_o and epc_o hold the chosen code and the PC of the instruction that was at commit. For an interrupt this is the PC of the killed instruction. Both registers hold their values in every other cycle.
- R7: The instruction at commit in a take cycle does not reach writeback (wb_valid_o is low in the next cycle). The instructions then in decode and execute also never reach writeback.
- R8: A killed instruction is a bubble, so a fault flag it carried never causes a later take.
- R9: redirect_o is high for exactly the one cycle after each take, with redirect_pc_o equal to HANDLER_PC.
- R10: A valid instruction that leaves the memory stage without a take shows up in the next cycle as wb_valid_o high, with wb_pc_o equal to its PC.
- R11: An instruction presented on the fetch inputs in a take cycle is discarded and never reaches writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_valid_i | input | 1 | An instruction is fetched this cycle |
| fe_pc_i | input | PC_W | PC of the fetched instruction |
| fe_fault_i | input | 1 | Fetch address fault of the fetched instruction |
| id_illegal_i | input | 1 | Illegal opcode for the instruction in decode |
| ex_ovf_i | input | 1 | Overflow for the instruction in execute |
| mem_daddr_i | input | 1 | Data address fault for the instruction in memory |
| irq_i | input | 1 | External interrupt request (level) |
| take_o | output | 1 | Exception taken at commit this cycle |
| kill_o | output | 1 | Kill fetch, decode, execute and writeback this cycle |
| redirect_o | output | 1 | Fetch must use redirect_pc_o this cycle |
| redirect_pc_o | output | PC_W | Handler address |
| cause_o | output | 3 | Cause code of the last exception taken |
| epc_o | output | PC_W | PC of the last instruction taken |
| wb_valid_o | output | 1 | An instruction enters writeback |
| wb_pc_o | output | PC_W | PC of the instruction entering writeback |

## Verification
Several fault sources often land on one instruction in the same cycle at commit. A new data address fault can join flags carried from earlier stages, and an interrupt can arrive while the committing instruction already holds a fault. Directed sequences load one instruction with every combination of the later faults and hold irq_i high against a faulting instruction. Random traffic with frequent flags and interrupts then produces these collisions many times. Each cycle is judged against a bench model of the flag-carrying pipeline. The model predicts take_o, the cause code, the EPC and which instructions survive into writeback.

// File: rtl/exc_pkg.sv
package exc_pkg;
   // number of fault sources, one per stage from fetch to memory
   localparam int NSRC   = 4;
   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      CAUSE_IRQ     = 3'd0,
      CAUSE_FETCH   = 3'd1,
      CAUSE_ILLEGAL = 3'd2,
      CAUSE_OVF     = 3'd3,
      CAUSE_DADDR   = 3'd4
   } cause_e;

   // bit i set: fault found in stage i (0 fetch .. 3 memory)
   typedef logic [NSRC-1:0] flag_t;
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
   import exc_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kill_i,
   input  logic            in_valid_i,
   input  logic [PC_W-1:0] in_pc_i,
   input  flag_t           in_flags_i,
   output logic            out_valid_o,
   output logic [PC_W-1:0] out_pc_o,
   output flag_t           out_flags_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         out_pc_o    <= '0;
         out_flags_o <= '0;
      end else if (kill_i) begin
         // squashed slot becomes a bubble with no pending fault
         out_valid_o <= 1'b0;
         out_flags_o <= '0;
      end else begin
         out_valid_o <= in_valid_i;
         out_pc_o    <= in_pc_i;
         out_flags_o <= in_valid_i ? in_flags_i : '0;
      end
   end

   // R8
   bubble_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid_o |-> (out_flags_o == '0));
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
   import exc_pkg::*;
(
   input  flag_t  flags_i,
   input  logic   irq_i,
   output logic   exc_o,
   output cause_e cause_o
);
   always_comb begin
      exc_o   = |flags_i;
      cause_o = CAUSE_IRQ;
      if (!irq_i) begin
         // scan from the latest stage down so the earliest fault wins
         for (int i = NSRC - 1; i >= 0; i--) begin
            if (flags_i[i]) cause_o = cause_e'(CODE_W'(i + 1));
         end
      end
   end
endmodule

// File: rtl/exc_csr.sv
module exc_csr
   import exc_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  cause_e            cause_i,
   input  logic              commit_valid_i,
   input  logic [PC_W-1:0]   commit_pc_i,
   output logic [CODE_W-1:0] cause_o,
   output logic [PC_W-1:0]   epc_o,
   output logic              redirect_o,
   output logic [PC_W-1:0]   redirect_pc_o,
   output logic              wb_valid_o,
   output logic [PC_W-1:0]   wb_pc_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_o    <= '0;
         epc_o      <= '0;
         redirect_o <= 1'b0;
         wb_valid_o <= 1'b0;
         wb_pc_o    <= '0;
      end else begin
         redirect_o <= take_i;
         wb_valid_o <= commit_valid_i && !take_i;
         if (take_i) begin
            cause_o <= cause_i;
            epc_o   <= commit_pc_i;
         end
         if (commit_valid_i && !take_i) wb_pc_o <= commit_pc_i;
      end
   end

   assign redirect_pc_o = HANDLER_PC;

   // R9
   redirect_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> !wb_valid_o);
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
   import exc_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fe_valid_i,
   input  logic [PC_W-1:0]   fe_pc_i,
   input  logic              fe_fault_i,
   input  logic              id_illegal_i,
   input  logic              ex_ovf_i,
   input  logic              mem_daddr_i,
   input  logic              irq_i,
   output logic              take_o,
   output logic              kill_o,
   output logic              redirect_o,
   output logic [PC_W-1:0]   redirect_pc_o,
   output logic [CODE_W-1:0] cause_o,
   output logic [PC_W-1:0]   epc_o,
   output logic              wb_valid_o,
   output logic [PC_W-1:0]   wb_pc_o
);
   // stage registers: 0 decode, 1 execute, 2 memory (commit)
   localparam int NSTG = NSRC - 1;
   localparam int CMT  = NSTG - 1;

   if (PC_W < 2 || PC_W > 64) begin : g_pcw_bad
      $error("exc_commit_unit: PC_W out of range");
   end
   if (NSTG < 1) begin : g_stg_bad
      $error("exc_commit_unit: need at least one stage register");
   end

   logic            sv  [NSTG];
   logic [PC_W-1:0] spc [NSTG];
   flag_t           sfl [NSTG];
   logic [NSTG-1:0] det;
   flag_t           cflags;
   logic            exc;
   cause_e          csel;
   logic            take;

   // det[k]: fault discovered for the instruction now in stage k
   assign det = {mem_daddr_i, ex_ovf_i, id_illegal_i};

   for (genvar k = 0; k < NSTG; k++) begin : g_stage
      logic            in_v;
      logic [PC_W-1:0] in_pc;
      flag_t           in_fl;
      if (k == 0) begin : g_head
         assign in_v  = fe_valid_i;
         assign in_pc = fe_pc_i;
         assign in_fl = flag_t'(fe_fault_i);
      end else begin : g_body
         assign in_v  = sv[k-1];
         assign in_pc = spc[k-1];
         assign in_fl = sfl[k-1] | (flag_t'(det[k-1] & sv[k-1]) << k);
      end
      exc_stage_reg #(.PC_W(PC_W)) u_reg (
         .clk         (clk),
         .rst_n       (rst_n),
         .kill_i      (take),
         .in_valid_i  (in_v),
         .in_pc_i     (in_pc),
         .in_flags_i  (in_fl),
         .out_valid_o (sv[k]),
         .out_pc_o    (spc[k]),
         .out_flags_o (sfl[k])
      );
   end

   assign cflags = sv[CMT] ? (sfl[CMT] | (flag_t'(det[CMT]) << NSTG)) : '0;

   exc_cause_sel u_sel (
      .flags_i (cflags),
      .irq_i   (irq_i),
      .exc_o   (exc),
      .cause_o (csel)
   );

   assign take   = sv[CMT] && (irq_i || exc);
   assign take_o = take;
   assign kill_o = take;

   exc_csr #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_csr (
      .clk            (clk),
      .rst_n          (rst_n),
      .take_i         (take),
      .cause_i        (csel),
      .commit_valid_i (sv[CMT]),
      .commit_pc_i    (spc[CMT]),
      .cause_o        (cause_o),
      .epc_o          (epc_o),
      .redirect_o     (redirect_o),
      .redirect_pc_o  (redirect_pc_o),
      .wb_valid_o     (wb_valid_o),
      .wb_pc_o        (wb_pc_o)
   );

   // R2
   take_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> sv[CMT]);
   // R5
   idle_irq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sv[CMT] && irq_i) |=> (redirect_o == 1'b0));
   // R4
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && irq_i) |=> (cause_o == CAUSE_IRQ));
   // R6
   epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (epc_o == $past(spc[CMT])));
   // R7
   flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (!sv[0] && !sv[1] && !sv[CMT] && !wb_valid_o));
   // R9
   redirect_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> redirect_o);
endmodule

// File: tb/exc_commit_unit_bench.sv
module exc_commit_unit_bench;
   localparam int              CLK_P  = 10;
   localparam int              PC_W   = 32;
   localparam logic [PC_W-1:0] HANDLR = 32'h0000_0180;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            fe_valid_i, fe_fault_i, id_illegal_i, ex_ovf_i, mem_daddr_i, irq_i;
   logic [PC_W-1:0] fe_pc_i;
   logic            take_o, kill_o, redirect_o, wb_valid_o;
   logic [PC_W-1:0] redirect_pc_o, epc_o, wb_pc_o;
   logic [2:0]      cause_o;

   exc_commit_unit #(.PC_W(PC_W), .HANDLER_PC(HANDLR)) u_exc_commit_unit (
      .clk(clk), .rst_n(rst_n), .fe_valid_i(fe_valid_i), .fe_pc_i(fe_pc_i),
      .fe_fault_i(fe_fault_i), .id_illegal_i(id_illegal_i), .ex_ovf_i(ex_ovf_i),
      .mem_daddr_i(mem_daddr_i), .irq_i(irq_i), .take_o(take_o), .kill_o(kill_o),
      .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .cause_o(cause_o),
      .epc_o(epc_o), .wb_valid_o(wb_valid_o), .wb_pc_o(wb_pc_o)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int since_take = 100;
   int steps = 0;

   // reference model of the flag-carrying pipeline
   logic            mv  [3];
   logic [PC_W-1:0] mpc [3];
   logic [3:0]      mfl [3];
   logic [2:0]      x_cause;
   logic [PC_W-1:0] x_epc, x_wbpc;
   logic            x_redir, x_wbv;

   function automatic logic [2:0] prio_code(input logic [3:0] fl, input logic irq);
      if (irq) return 3'd0;
      for (int i = 0; i < 4; i++) if (fl[i]) return 3'(i + 1);
      return 3'd0;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_regs();
      string t;
      t = (steps == 0) ? "R1" : "R6";
      chk(t, cause_o, x_cause);
      chk(t, epc_o, x_epc);
      chk((steps == 0) ? "R1" : "R9", redirect_o, x_redir);
      if (x_redir) chk("R9", redirect_pc_o, HANDLR);
      t = (steps == 0) ? "R1" : ((since_take <= 4) ? "R7,R11" : "R10");
      chk(t, wb_valid_o, x_wbv);
      if (x_wbv) chk("R10", wb_pc_o, x_wbpc);
   endtask

   task automatic step(input logic fv, input logic [PC_W-1:0] fpc, input logic ff,
                       input logic il, input logic ov, input logic da, input logic irq);
      logic [3:0] cfl;
      logic       tk;
      logic [2:0] code;
      @(negedge clk);
      check_regs();
      fe_valid_i = fv; fe_pc_i = fpc; fe_fault_i = ff;
      id_illegal_i = il; ex_ovf_i = ov; mem_daddr_i = da; irq_i = irq;
      #1;
      cfl  = mv[2] ? (mfl[2] | {da, 3'b000}) : 4'b0;
      tk   = mv[2] && (irq || (cfl != 0));
      code = prio_code(cfl, irq);
      chk(!mv[2] ? "R5" : (since_take <= 3 ? "R8" : "R2"), take_o, tk);
      chk("R7", kill_o, tk);
      since_take++;
      if (tk) begin
         x_cause = code; x_epc = mpc[2]; x_redir = 1'b1; x_wbv = 1'b0;
         for (int k = 0; k < 3; k++) begin mv[k] = 1'b0; mfl[k] = 4'b0; end
         since_take = 1;
      end else begin
         x_redir = 1'b0;
         x_wbv = mv[2];
         if (mv[2]) x_wbpc = mpc[2];
         mv[2] = mv[1]; mpc[2] = mpc[1]; mfl[2] = mv[1] ? (mfl[1] | {1'b0, ov, 2'b00}) : 4'b0;
         mv[1] = mv[0]; mpc[1] = mpc[0]; mfl[1] = mv[0] ? (mfl[0] | {2'b00, il, 1'b0}) : 4'b0;
         mv[0] = fv; mpc[0] = fpc; mfl[0] = fv ? {3'b000, ff} : 4'b0;
      end
      steps++;
   endtask

   task automatic bubble(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0;
      fe_valid_i = 0; fe_pc_i = '0; fe_fault_i = 0; id_illegal_i = 0;
      ex_ovf_i = 0; mem_daddr_i = 0; irq_i = 0;
      for (int k = 0; k < 3; k++) begin mv[k] = 0; mpc[k] = '0; mfl[k] = '0; end
      x_cause = 0; x_epc = '0; x_wbpc = '0; x_redir = 0; x_wbv = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R3: all four faults on one instruction, fetch wins (code 1)
      step(1, 32'h1000, 1, 0, 0, 0, 0);
      step(0, '0, 0, 1, 0, 0, 0);
      step(0, '0, 0, 0, 1, 0, 0);
      step(0, '0, 0, 0, 0, 1, 0);
      bubble(2);
      // R3: illegal + data address, illegal wins (code 2)
      step(1, 32'h2000, 0, 0, 0, 0, 0);
      step(0, '0, 0, 1, 0, 0, 0);
      step(0, '0, 0, 0, 0, 0, 0);
      step(0, '0, 0, 0, 0, 1, 0);
      bubble(2);
      // R3: overflow + data address, overflow wins (code 3)
      step(1, 32'h3000, 0, 0, 0, 0, 0);
      step(0, '0, 0, 0, 0, 0, 0);
      step(0, '0, 0, 0, 1, 0, 0);
      step(0, '0, 0, 0, 0, 1, 0);
      bubble(2);
      // R4: interrupt against a faulting instruction at commit, R11 fetch in take cycle
      step(1, 32'h4000, 1, 0, 0, 0, 0);
      step(1, 32'h4004, 0, 0, 0, 0, 0);
      step(1, 32'h4008, 0, 0, 0, 0, 0);
      step(1, 32'h400c, 0, 0, 0, 1, 1);
      bubble(5);
      // R5: interrupt with an empty pipeline
      step(0, '0, 0, 0, 0, 0, 1);
      step(0, '0, 0, 0, 0, 0, 1);
      // R10: clean stream
      for (int i = 0; i < 6; i++) step(1, 32'h5000 + 4 * i, 0, 0, 0, 0, 0);
      bubble(4);

      // constrained random traffic
      void'($urandom(32'd1234));
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 4) != 0, $urandom & 32'hFFFF_FFFC,
              ($urandom % 14) == 0, ($urandom % 12) == 0, ($urandom % 12) == 0,
              ($urandom % 14) == 0, ($urandom % 16) == 0);
      end
      bubble(4);
      @(negedge clk);
      check_regs();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule